// File: doc/BRIEF.md
# Asynchronous Fault Status Capture Register

This block gathers asynchronous memory and bus error events into a single 64-bit status word. Each error type has its own sticky flag. The flag is set when the event arrives and stays set until software writes a one to its position. The block also keeps one shared fault address and two syndrome fields: a 9-bit data-ECC syndrome and a 4-bit tag-ECC syndrome. These describe the most severe pending error. Once captured they are frozen, and a later error can replace them only if it is more severe.

Error types are grouped into three severity classes. Uncorrectable errors rank highest, software-correctable errors come next, and hardware-corrected errors rank lowest. Which class each type belongs to is set by two parameter masks. A small capture state machine records which class currently owns the address and syndromes. Its states are OPEN (nothing held), HELD_HWC, HELD_SWC and HELD_UNC. The machine has these transitions:
- **Capture**: OPEN goes to any held state.
- **Upgrade**: a held state goes to a higher held state.
- **Release**: a held state returns to OPEN when software clears the sticky flag of the held error.

A repeat flag and a privilege flag complete the word. Events that repeat inside one bus transaction, recognised by the same transaction tag, are dropped. A register write port performs write-one-to-clear. The status word is always visible, and reading it has no side effect.

Top module: `fault_status_capture`

## Requirements
- R1: After reset, `status_word` and `fault_addr` are all zero and the capture machine is OPEN.
- R2: An accepted event of type t (0..18) sets status bit 33+t one cycle later, and the bit stays set until cleared. Accepted means `evt_valid` is high, t is below 19, and the tag differs from the last accepted tag.
- R3: A `reg_wr` clears exactly those of bits 53..33 that are one in `reg_wdata`. Zero bits, and all bits outside 53..33, change nothing.
- R4: In the OPEN state, an accepted event whose flag is clear is captured. `fault_addr` takes `evt_addr`, bits 8..0 take `evt_esyn` and bits 19..16 take `evt_msyn`, all one cycle later.
- R5: While a capture is held, an event of the same or lower class leaves the address and both syndromes unchanged.
- R6: An event of a higher class than the held one, whose flag is clear, overwrites the held address and syndromes.
- R7: An event whose own flag is already set never recaptures the address or syndromes.
- R8: Clearing the flag of the held error returns the machine to OPEN even if other flags stay set. The held values remain until the next capture.
- R9: Bit 53 (repeat flag) is set when an uncorrectable or software-correctable event arrives while its own flag is set. A repeated hardware-corrected event never sets it.
- R10: An event carrying the same transaction tag as the last accepted event is ignored completely: no flag, no repeat flag, no capture.
- R11: Bit 52 is set when an accepted event arrives with `evt_priv` high. Both bit 52 and bit 53 clear by writing one.
- R12: When an event of type t and a write clearing bit 33+t fall in the same cycle, the bit stays set. If t is the held error, the capture also stays held.
- R13: Default class map (type index → class):
  - uncorrectable: 1, 2, 4, 6, 8, 10, 11, 12, 14, 16, 17, 18
  - software-correctable: 9
  - hardware-corrected: all other types

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_type | input | TYPE_W (5) | Error type index |
| evt_addr | input | ADDR_W (40) | Address associated with the event |
| evt_esyn | input | 9 | Data-ECC syndrome of the event |
| evt_msyn | input | 4 | Tag-ECC syndrome of the event |
| evt_txn | input | TXN_W (4) | Bus transaction tag |
| evt_priv | input | 1 | Processor was privileged at detection |
| reg_wr | input | 1 | Write-one-to-clear strobe |
| reg_wdata | input | 64 | Clear mask |
| status_word | output | 64 | Sticky flags, repeat/privilege flags and syndromes |
| fault_addr | output | ADDR_W (40) | Shared captured fault address |

## Verification
Two functions can coincide in one cycle: a new event and a software clear. The clear can target the same flag as the event, or the flag of the held capture. The bench provokes this by driving both on one edge. It judges the result against an arithmetic model that applies the event's set after the clear, and checks both the release decision and whether a capture occurs. The same model also scores sweeps over every ordered pair of distinct types and over a repeat of every type.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam int STAT_W   = 64;
    localparam int ESYN_W   = 9;
    localparam int MSYN_W   = 4;
    localparam int ESYN_LO  = 0;
    localparam int MSYN_LO  = 16;
    localparam int FLAG_LO  = 33;
    localparam int PRIV_BIT = 52;
    localparam int REP_BIT  = 53;

    typedef enum logic [1:0] {
        HELD_NONE = 2'd0,
        HELD_HWC  = 2'd1,
        HELD_SWC  = 2'd2,
        HELD_UNC  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/fsc_txn_filter.sv
module fsc_txn_filter #(
    parameter int ERR_N  = 19,
    parameter int TYPE_W = 5,
    parameter int TXN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [TYPE_W-1:0] evt_type,
    input  logic [TXN_W-1:0]  evt_txn,
    output logic              evt_ok
);
    localparam logic [TYPE_W:0] TYPE_LIM = (TYPE_W+1)'(ERR_N);

    logic             seen_q;
    logic [TXN_W-1:0] last_txn_q;
    logic             repeat_hit;

    always_comb begin
        repeat_hit = seen_q && (evt_txn == last_txn_q);
        evt_ok     = evt_valid && ({1'b0, evt_type} < TYPE_LIM) && !repeat_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q     <= 1'b0;
            last_txn_q <= '0;
        end else if (evt_ok) begin
            seen_q     <= 1'b1;
            last_txn_q <= evt_txn;
        end
    end
endmodule

// File: rtl/fsc_flag_bank.sv
module fsc_flag_bank #(
    parameter int               ERR_N   = 19,
    parameter int               TYPE_W  = 5,
    parameter logic [ERR_N-1:0] HWC_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_ok,
    input  logic [TYPE_W-1:0] evt_type,
    input  logic              evt_priv,
    input  logic [ERR_N-1:0]  clr_vec,
    input  logic              clr_rep,
    input  logic              clr_priv,
    output logic [ERR_N-1:0]  flags_q,
    output logic              bit_was_set,
    output logic              rep_q,
    output logic              priv_q
);
    logic [ERR_N-1:0] set_vec;

    always_comb begin
        set_vec     = evt_ok ? (ERR_N'(1) << evt_type) : '0;
        bit_was_set = |(flags_q & set_vec);
    end

    for (genvar i = 0; i < ERR_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rep_q  <= 1'b0;
            priv_q <= 1'b0;
        end else begin
            if (bit_was_set && !(|(set_vec & HWC_MASK))) rep_q <= 1'b1;
            else if (clr_rep)                             rep_q <= 1'b0;
            if (evt_ok && evt_priv) priv_q <= 1'b1;
            else if (clr_priv)      priv_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fsc_capture_fsm.sv
module fsc_capture_fsm
    import fsc_pkg::*;
#(
    parameter int               ERR_N   = 19,
    parameter int               TYPE_W  = 5,
    parameter logic [ERR_N-1:0] UNC_MASK = '0,
    parameter logic [ERR_N-1:0] SWC_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_ok,
    input  logic [TYPE_W-1:0] evt_type,
    input  logic              bit_was_set,
    input  logic [ERR_N-1:0]  clr_vec,
    output logic              cap_fire,
    output cap_state_e        cap_state,
    output logic [TYPE_W-1:0] lock_idx
);
    cap_state_e evt_cls, eff_state, state_d;
    logic       release_hit, beats;
    logic [ERR_N-1:0] evt_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_state <= HELD_NONE;
            lock_idx  <= '0;
        end else begin
            cap_state <= state_d;
            if (cap_fire) lock_idx <= evt_type;
        end
    end

    always_comb begin
        evt_vec = ERR_N'(1) << evt_type;
        if (|(evt_vec & UNC_MASK))      evt_cls = HELD_UNC;
        else if (|(evt_vec & SWC_MASK)) evt_cls = HELD_SWC;
        else                            evt_cls = HELD_HWC;

        release_hit = (cap_state != HELD_NONE) && clr_vec[lock_idx]
                      && !(evt_ok && (evt_type == lock_idx));
        eff_state = release_hit ? HELD_NONE : cap_state;

        unique case (eff_state)
            HELD_NONE: beats = 1'b1;
            HELD_HWC:  beats = (evt_cls == HELD_SWC) || (evt_cls == HELD_UNC);
            HELD_SWC:  beats = (evt_cls == HELD_UNC);
            HELD_UNC:  beats = 1'b0;
            default:   beats = 1'b0;
        endcase

        cap_fire = evt_ok && !bit_was_set && beats;
        state_d  = cap_fire ? evt_cls : eff_state;
    end
endmodule

// File: rtl/fault_status_capture.sv
module fault_status_capture
    import fsc_pkg::*;
#(
    parameter int               ERR_N    = 19,
    parameter int               ADDR_W   = 40,
    parameter int               TXN_W    = 4,
    parameter int               TYPE_W   = $clog2(ERR_N),
    parameter logic [ERR_N-1:0] UNC_MASK = 19'h75D56,
    parameter logic [ERR_N-1:0] SWC_MASK = 19'h00200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [TYPE_W-1:0]  evt_type,
    input  logic [ADDR_W-1:0]  evt_addr,
    input  logic [ESYN_W-1:0]  evt_esyn,
    input  logic [MSYN_W-1:0]  evt_msyn,
    input  logic [TXN_W-1:0]   evt_txn,
    input  logic               evt_priv,
    input  logic               reg_wr,
    input  logic [STAT_W-1:0]  reg_wdata,
    output logic [STAT_W-1:0]  status_word,
    output logic [ADDR_W-1:0]  fault_addr
);
    localparam logic [ERR_N-1:0] HWC_MASK = ~(UNC_MASK | SWC_MASK);

    logic              evt_ok, bit_was_set, cap_fire, rep_q, priv_q;
    logic [ERR_N-1:0]  clr_vec, flags_q;
    cap_state_e        cap_state;
    logic [TYPE_W-1:0] lock_idx;
    logic [ESYN_W-1:0] esyn_q;
    logic [MSYN_W-1:0] msyn_q;

    assign clr_vec = reg_wr ? reg_wdata[FLAG_LO +: ERR_N] : '0;

    fsc_txn_filter #(.ERR_N(ERR_N), .TYPE_W(TYPE_W), .TXN_W(TXN_W)) u_filt (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
        .evt_txn(evt_txn), .evt_ok(evt_ok)
    );

    fsc_flag_bank #(.ERR_N(ERR_N), .TYPE_W(TYPE_W), .HWC_MASK(HWC_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_ok(evt_ok), .evt_type(evt_type),
        .evt_priv(evt_priv), .clr_vec(clr_vec),
        .clr_rep(reg_wr && reg_wdata[REP_BIT]),
        .clr_priv(reg_wr && reg_wdata[PRIV_BIT]),
        .flags_q(flags_q), .bit_was_set(bit_was_set), .rep_q(rep_q), .priv_q(priv_q)
    );

    fsc_capture_fsm #(.ERR_N(ERR_N), .TYPE_W(TYPE_W),
                      .UNC_MASK(UNC_MASK), .SWC_MASK(SWC_MASK)) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt_ok(evt_ok), .evt_type(evt_type),
        .bit_was_set(bit_was_set), .clr_vec(clr_vec), .cap_fire(cap_fire),
        .cap_state(cap_state), .lock_idx(lock_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_addr <= '0;
            esyn_q     <= '0;
            msyn_q     <= '0;
        end else if (cap_fire) begin
            fault_addr <= evt_addr;
            esyn_q     <= evt_esyn;
            msyn_q     <= evt_msyn;
        end
    end

    always_comb begin
        status_word                        = '0;
        status_word[ESYN_LO +: ESYN_W]     = esyn_q;
        status_word[MSYN_LO +: MSYN_W]     = msyn_q;
        status_word[FLAG_LO +: ERR_N]      = flags_q;
        status_word[PRIV_BIT]              = priv_q;
        status_word[REP_BIT]               = rep_q;
    end
endmodule

// File: rtl/fault_status_capture_chk.sv
module fault_status_capture_chk
    import fsc_pkg::*;
#(
    parameter int ERR_N  = 19,
    parameter int ADDR_W = 40,
    parameter int TYPE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [ERR_N-1:0]  flags_q,
    input logic [ERR_N-1:0]  clr_vec,
    input cap_state_e        cap_state,
    input logic [TYPE_W-1:0] lock_idx,
    input logic              cap_fire,
    input logic              rep_q,
    input logic [ADDR_W-1:0] fault_addr
);
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_vec)) == $past(flags_q & ~clr_vec))); // R2
    AST_FIRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (cap_state != HELD_NONE)); // R4
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire |=> $stable(fault_addr)); // R5
    AST_HELD_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state != HELD_NONE) |-> flags_q[lock_idx]); // R8
    AST_REP_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rep_q) |-> $past(evt_valid)); // R9
endmodule

bind fault_status_capture fault_status_capture_chk #(
    .ERR_N(ERR_N), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .flags_q(flags_q),
    .clr_vec(clr_vec), .cap_state(cap_state), .lock_idx(lock_idx),
    .cap_fire(cap_fire), .rep_q(rep_q), .fault_addr(fault_addr)
);

// File: tb/fault_status_capture_tb_top.sv
module fault_status_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 19;
    localparam logic [NT-1:0] UNC = 19'h75D56;
    localparam logic [NT-1:0] SWC = 19'h00200;

    logic        clk = 0, rst_n = 0;
    logic        evt_valid = 0, evt_priv = 0, reg_wr = 0;
    logic [4:0]  evt_type = 0;
    logic [39:0] evt_addr = 0;
    logic [8:0]  evt_esyn = 0;
    logic [3:0]  evt_msyn = 0;
    logic [3:0]  evt_txn = 0;
    logic [63:0] reg_wdata = 0;
    logic [63:0] status_word;
    logic [39:0] fault_addr;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    logic [NT-1:0] m_fl = 0;
    logic [39:0]   m_addr = 0;
    logic [8:0]    m_es = 0;
    logic [3:0]    m_ms = 0;
    int            m_lvl = 0, m_lock = 0;
    bit            m_rep = 0, m_priv = 0, m_seen = 0;
    logic [3:0]    m_last = 0;
    logic [3:0]    txn_ctr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fault_status_capture dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_type(evt_type),
        .evt_addr(evt_addr), .evt_esyn(evt_esyn), .evt_msyn(evt_msyn),
        .evt_txn(evt_txn), .evt_priv(evt_priv), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .status_word(status_word), .fault_addr(fault_addr)
    );

    function automatic int cls(int t);
        return UNC[t] ? 3 : (SWC[t] ? 2 : 1);
    endfunction

    function automatic logic [63:0] m_word();
        logic [63:0] w = '0;
        w[8:0] = m_es; w[19:16] = m_ms; w[51:33] = m_fl;
        w[52] = m_priv; w[53] = m_rep;
        return w;
    endfunction

    task automatic check(input string tag);
        total++;
        if (status_word !== m_word() || fault_addr !== m_addr) begin
            bad++;
            $display("FAIL %s: status=%h addr=%h expected status=%h addr=%h",
                     tag, status_word, fault_addr, m_word(), m_addr);
        end
    endtask

    task automatic cyc(input bit ev, input int ty, input logic [39:0] a,
                       input logic [8:0] es, input logic [3:0] ms,
                       input logic [3:0] tx, input bit pv,
                       input bit wr, input logic [63:0] wd);
        bit ok, was, rel, cap;
        logic [NT-1:0] clr;
        evt_valid = ev; evt_type = 5'(ty); evt_addr = a; evt_esyn = es;
        evt_msyn = ms; evt_txn = tx; evt_priv = pv; reg_wr = wr; reg_wdata = wd;
        ok  = ev && ty < NT && !(m_seen && tx == m_last);
        was = ok && m_fl[ty];
        clr = wr ? wd[51:33] : '0;
        rel = (m_lvl != 0) && clr[m_lock] && !(ok && ty == m_lock);
        cap = ok && !was && cls(ty) > (rel ? 0 : m_lvl);
        if (ok) begin m_seen = 1; m_last = tx; end
        if (cap) begin
            m_addr = a; m_es = es; m_ms = ms; m_lvl = cls(ty); m_lock = ty;
        end else if (rel) m_lvl = 0;
        if (was && cls(ty) != 1) m_rep = 1;
        else if (wr && wd[53]) m_rep = 0;
        if (ok && pv) m_priv = 1;
        else if (wr && wd[52]) m_priv = 0;
        m_fl = (m_fl & ~clr) | (ok ? (NT'(1) << ty) : '0);
        @(posedge clk);
        #2;
        evt_valid = 0; reg_wr = 0;
    endtask

    task automatic ev(input int ty, input logic [39:0] a, input bit pv = 0);
        txn_ctr++;
        cyc(1, ty, a, 9'(a * 3), 4'(a), txn_ctr, pv, 0, '0);
    endtask

    task automatic clr_all();
        cyc(0, 0, '0, '0, '0, '0, 0, 1, 64'h003F_FFFE_0000_0000);
    endtask

    task automatic clr_bits(input logic [63:0] w);
        cyc(0, 0, '0, '0, '0, '0, 0, 1, w);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        check("R1 reset");

        // R2/R4 single event per type
        for (int t = 0; t < NT; t++) begin
            clr_all();
            ev(t, 40'h10_0000_0000 + 40'(t * 17));
            check("R2 flag set / R4 capture");
        end
        clr_all();
        check("R3 clear all");

        // R3 partial clear, syndrome bits in mask ignored
        ev(0, 40'h111); ev(3, 40'h222); ev(5, 40'h333);
        clr_bits((64'h1 << 36) | 64'h000F_01FF);
        check("R3 partial clear");
        clr_all();

        // R5/R6 ordered pair sweep (R13 class map)
        for (int a = 0; a < NT; a++)
            for (int b = 0; b < NT; b++) begin
                if (a == b) continue;
                clr_all();
                ev(a, 40'(1000 + a));
                ev(b, 40'(2000 + b));
                if (cls(b) > cls(a)) check("R6 higher overwrites");
                else                 check("R5 held against same/lower");
            end

        // R9 repeat flag per type
        for (int t = 0; t < NT; t++) begin
            clr_all();
            ev(t, 40'h55);
            ev(t, 40'h66);
            check(cls(t) == 1 ? "R9 hw repeat no flag" : "R9 repeat flag");
        end
        clr_all();

        // R7/R8 release and no recapture of already-set flag
        ev(1, 40'hA0A0);
        ev(0, 40'hB0B0);
        clr_bits(64'h1 << 34);
        check("R8 release keeps values");
        ev(0, 40'hC0C0);
        check("R7 set flag no recapture");
        ev(3, 40'hD0D0);
        check("R8 new capture after release");
        clr_all();

        // R10 same transaction tag
        txn_ctr++;
        cyc(1, 4, 40'h400, 9'h4, 4'h4, txn_ctr, 0, 0, '0);
        cyc(1, 9, 40'h900, 9'h9, 4'h9, txn_ctr, 0, 0, '0);
        check("R10 same txn other type ignored");
        cyc(1, 4, 40'h401, 9'h5, 4'h5, txn_ctr, 0, 0, '0);
        check("R10 same txn repeat ignored");
        clr_all();

        // R11 privilege
        ev(7, 40'h777, 1);
        check("R11 priv set");
        clr_bits(64'h1 << 52);
        check("R11 priv clear");
        clr_all();

        // R12 simultaneous event and clear
        ev(5, 40'h505);
        txn_ctr++;
        cyc(1, 5, 40'h506, 9'h1, 4'h1, txn_ctr, 0, 1, 64'h1 << 38);
        check("R12 event wins over clear");
        clr_all();
        ev(2, 40'h202);
        txn_ctr++;
        cyc(1, 10, 40'h1010, 9'h2, 4'h2, txn_ctr, 0, 1, 64'h1 << 35);
        check("R12 clear of held plus new capture");
        txn_ctr++;
        cyc(1, 10, 40'h1111, 9'h3, 4'h3, txn_ctr, 0, 1, 64'h1 << 43);
        check("R12 held flag kept by same-type event");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule